// File: doc/BRIEF.md
# Line Sync Pulse Generator

This block sits behind a sync slicer and its noise filter. It watches an active-low composite sync stream, one sample per timebase tick, and produces two active-low timing pulses for each video line. The first is a line sync pulse of fixed width, started by the leading (falling) edge of a sync tip. The second is a clamp-window pulse of fixed width, started by the trailing (rising) edge of that tip. Both widths are counted in ticks. Edges that arrive much sooner than one nominal line period after the last line start are treated as half-line equalizing or serration pulses. They are dropped, so vertical blanking does not double the line rate.

The block qualifies the line rate before it trusts its input. Line starts must arrive at close to the nominal spacing for a run of consecutive lines before the outputs are released. A long silence withdraws that trust again. While the block is not trusted, both sync outputs stay high and a signal-lost flag is raised. A separate active-high clamp strobe then keeps firing at the nominal line period, so a downstream DC-restore loop still gets a regular sample window when no video is present. While locked, that clamp strobe follows the clamp-window pulse.

Top module: `hsync_porch_gen`

## Requirements
- R1: When locked, `hsync_n` goes low in the tick that accepts a line start and stays low for exactly HS_WIDTH ticks (default 12).
- R2: When locked, `porch_n` goes low in the first rising edge of `sync_n` that follows an accepted line start and stays low for exactly BP_WIDTH ticks (default 29).
- R3: A falling edge of `sync_n` is accepted as a line start only if at least P - floor(P/4) ticks have passed since the previous accepted start, where P is `line_period`. The first falling edge after reset is always accepted.
- R4: A falling edge that is not accepted does not start `hsync_n`, and its trailing rising edge does not start `porch_n`.
- R5: Lock is declared at the accepted start that completes 8 consecutive accepted intervals, each within P - floor(P/8) to P + floor(P/8) ticks inclusive.
- R6: An accepted interval outside that window restarts the run of good intervals but does not drop an existing lock.
- R7: Lock is dropped in the tick at which 4*P ticks have passed since the last accepted start.
- R8: While unlocked, `hsync_n` and `porch_n` are held high and `los` is 1. While locked, `los` is 0.
- R9: `clamp` is active high. While locked it equals the clamp-window pulse. While unlocked it free-runs, high for BP_WIDTH ticks in every P ticks.
- R10: `sync_n` is sampled and all state advances only in cycles with `tick_en` = 1. A pulse on `sync_n` between ticks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick enable |
| sync_n | input | 1 | Filtered composite sync, low during sync tips |
| line_period | input | PERIOD_W | Nominal line period in ticks |
| hsync_n | output | 1 | Line sync pulse, active low |
| porch_n | output | 1 | Clamp-window pulse, active low |
| clamp | output | 1 | Restore strobe, active high, free-running when unlocked |
| los | output | 1 | Signal-lost flag |

## Verification
The hardest case to reach from the ports is a half-line edge arriving while a lock is already held. Its rising edge must not re-arm the clamp window, and an accepted start that falls outside the window must reset the run of good intervals without touching the lock. The stimulus first builds a lock with a clean line sequence whose intervals include both window limits. It then injects mid-line pulses, an early edge one tick short of the acceptance limit, and an edge exactly at that limit. Afterwards it lets the signal die, and then re-locks through a deliberately long line. Counting the low ticks of each output per line shows whether a single edge was mishandled.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

  // earliest spacing at which a falling edge may start a new line
  function automatic int unsigned accept_floor(input int unsigned p);
    return p - (p >> 2);
  endfunction

  // lower bound of the interval window counted toward lock
  function automatic int unsigned window_lo(input int unsigned p);
    return p - (p >> 3);
  endfunction

  // upper bound of the interval window counted toward lock
  function automatic int unsigned window_hi(input int unsigned p);
    return p + (p >> 3);
  endfunction

  // silence length after which lock is withdrawn
  function automatic int unsigned loss_limit(input int unsigned p, input int unsigned lines);
    return p * lines;
  endfunction

endpackage

// File: rtl/hpg_edge_sampler.sv
module hpg_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic sync_n,
  output logic fall_ev,
  output logic rise_ev
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b1;
    else if (tick_en) prev_q <= sync_n;
  end

  assign fall_ev = tick_en &  prev_q & ~sync_n;
  assign rise_ev = tick_en & ~prev_q &  sync_n;

endmodule

// File: rtl/hpg_line_qualifier.sv
module hpg_line_qualifier #(
  parameter int PERIOD_W   = 10,
  parameter int LOCK_RUN   = 8,
  parameter int LOSS_LINES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                fall_ev,
  input  logic [PERIOD_W-1:0] line_period,
  output logic                accept_ev,
  output logic                in_window,
  output logic                loss_ev,
  output logic                locked
);
  import hpg_pkg::*;

  localparam int EW = PERIOD_W + 3;
  localparam int RW = $clog2(LOCK_RUN + 1);

  logic [EW-1:0] elapsed;
  logic [RW-1:0] run;
  logic [EW-1:0] lim_accept, lim_lo, lim_hi, lim_loss;

  assign lim_accept = EW'(accept_floor(32'(line_period)));
  assign lim_lo     = EW'(window_lo(32'(line_period)));
  assign lim_hi     = EW'(window_hi(32'(line_period)));
  assign lim_loss   = EW'(loss_limit(32'(line_period), 32'(LOSS_LINES)));

  assign accept_ev = fall_ev && (elapsed >= lim_accept);
  assign in_window = (elapsed >= lim_lo) && (elapsed <= lim_hi);
  assign loss_ev   = tick_en && !accept_ev && (elapsed == lim_loss);

  // ticks since last accepted start, saturating; reset to the top so the
  // first edge is accepted and counted as out of window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          elapsed <= '1;
    else if (accept_ev)                  elapsed <= EW'(1);
    else if (tick_en && elapsed != '1)   elapsed <= elapsed + EW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (loss_ev) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (accept_ev) begin
      if (!in_window) begin
        run <= '0;
      end else begin
        if (run != RW'(LOCK_RUN)) run <= run + RW'(1);
        if (run == RW'(LOCK_RUN - 1)) locked <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hpg_pulse_timer.sv
module hpg_pulse_timer #(
  parameter int WIDTH = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic trig,
  output logic active
);

  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       left <= '0;
    else if (trig)                    left <= CW'(WIDTH);
    else if (tick_en && left != '0)   left <= left - CW'(1);
  end

  assign active = (left != '0);

endmodule

// File: rtl/hpg_freerun.sv
module hpg_freerun #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [PERIOD_W-1:0] line_period,
  output logic                fire
);

  logic [PERIOD_W-1:0] phase;
  logic                wrap;

  assign wrap = (phase >= line_period - PERIOD_W'(1));
  assign fire = tick_en && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (fire)    phase <= '0;
    else if (tick_en) phase <= phase + PERIOD_W'(1);
  end

endmodule

// File: rtl/hsync_porch_gen.sv
module hsync_porch_gen #(
  parameter int PERIOD_W   = 10,
  parameter int HS_WIDTH   = 12,
  parameter int BP_WIDTH   = 29,
  parameter int LOCK_RUN   = 8,
  parameter int LOSS_LINES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                sync_n,
  input  logic [PERIOD_W-1:0] line_period,
  output logic                hsync_n,
  output logic                porch_n,
  output logic                clamp,
  output logic                los
);

  logic fall_ev, rise_ev;
  logic accept_ev, in_window, loss_ev, locked;
  logic armed, porch_trig, fr_fire;
  logic hs_act, bp_act, fr_act;

  hpg_edge_sampler i_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .sync_n  (sync_n),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev)
  );

  hpg_line_qualifier #(
    .PERIOD_W   (PERIOD_W),
    .LOCK_RUN   (LOCK_RUN),
    .LOSS_LINES (LOSS_LINES)
  ) i_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .fall_ev     (fall_ev),
    .line_period (line_period),
    .accept_ev   (accept_ev),
    .in_window   (in_window),
    .loss_ev     (loss_ev),
    .locked      (locked)
  );

  // only the trailing edge of an accepted tip opens the clamp window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (accept_ev) armed <= 1'b1;
    else if (rise_ev)   armed <= 1'b0;
  end

  assign porch_trig = rise_ev && armed;

  hpg_pulse_timer #(.WIDTH(HS_WIDTH)) i_hs_timer (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .trig (accept_ev), .active (hs_act)
  );

  hpg_pulse_timer #(.WIDTH(BP_WIDTH)) i_bp_timer (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .trig (porch_trig), .active (bp_act)
  );

  hpg_freerun #(.PERIOD_W(PERIOD_W)) i_free (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .line_period (line_period), .fire (fr_fire)
  );

  hpg_pulse_timer #(.WIDTH(BP_WIDTH)) i_fr_timer (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .trig (fr_fire), .active (fr_act)
  );

  assign hsync_n = ~(locked & hs_act);
  assign porch_n = ~(locked & bp_act);
  assign clamp   = locked ? bp_act : fr_act;
  assign los     = ~locked;

endmodule

// File: rtl/hpg_checker.sv
module hpg_checker #(
  parameter int PERIOD_W = 10,
  parameter int HS_WIDTH = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic [PERIOD_W-1:0] line_period,
  input logic                hsync_n,
  input logic                porch_n,
  input logic                clamp,
  input logic                los,
  input logic                accept_ev,
  input logic                in_window,
  input logic                loss_ev
);

  int hs_run;
  int gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hs_run <= 0;
    else if (hsync_n)      hs_run <= 0;
    else if (tick_en)      hs_run <= hs_run + 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap <= 32'h3fff_ffff;
    else if (accept_ev)                  gap <= 1;
    else if (tick_en && gap < 32'h3fff_ffff) gap <= gap + 1;
  end

  assert_hs_from_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> $past(accept_ev));

  assert_hs_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hs_run <= HS_WIDTH);

  assert_accept_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> (gap >= int'(line_period) - int'(line_period >> 2)));

  assert_lock_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(accept_ev && in_window));

  assert_drop_on_silence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(loss_ev));

  assert_blank_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> (hsync_n && porch_n));

  assert_tick_gating_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(hsync_n) && $stable(porch_n) && $stable(clamp) && $stable(los)));

endmodule

bind hsync_porch_gen hpg_checker #(
  .PERIOD_W (PERIOD_W),
  .HS_WIDTH (HS_WIDTH)
) i_hpg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .line_period (line_period),
  .hsync_n     (hsync_n),
  .porch_n     (porch_n),
  .clamp       (clamp),
  .los         (los),
  .accept_ev   (accept_ev),
  .in_window   (in_window),
  .loss_ev     (loss_ev)
);

// File: tb/test_hsync_porch_gen.sv
module test_hsync_porch_gen;

  localparam int CLK_PERIOD = 10;
  localparam int PW  = 8;
  localparam int P   = 40;
  localparam int HSW = 12;
  localparam int BPW = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          sync_n = 1'b1;
  logic [PW-1:0] line_period = PW'(P);
  logic          hsync_n, porch_n, clamp, los;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // per-line tallies
  int h_low, p_low, c_high, h_first, c_rise_a, c_rise_b, tick_no;
  logic c_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsync_porch_gen #(
    .PERIOD_W (PW), .HS_WIDTH (HSW), .BP_WIDTH (BPW),
    .LOCK_RUN (8), .LOSS_LINES (4)
  ) i_hsync_porch_gen (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .sync_n (sync_n),
    .line_period (line_period), .hsync_n (hsync_n), .porch_n (porch_n),
    .clamp (clamp), .los (los)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one tick: drive at negedge, tick edge, sample at following negedge
  task automatic do_tick(input logic v);
    @(negedge clk);
    sync_n  = v;
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    if (!hsync_n) begin
      if (h_first < 0) h_first = tick_no;
      h_low++;
    end
    if (!porch_n) p_low++;
    if (clamp) begin
      c_high++;
      if (!c_prev) begin
        c_rise_a = c_rise_b;
        c_rise_b = tick_no;
      end
    end
    c_prev = clamp;
    tick_no++;
    @(posedge clk);
  endtask

  task automatic clear_tally();
    h_low = 0; p_low = 0; c_high = 0; h_first = -1; tick_no = 0;
  endtask

  // a line of len ticks with a low tip of 3 ticks; optional extra half-line
  // tip at tick half_at, optional between-tick glitch before tick glitch_at
  task automatic run_line(input int len, input int half_at, input int glitch_at);
    clear_tally();
    for (int i = 0; i < len; i++) begin
      if (i == glitch_at) begin
        @(negedge clk); sync_n = 1'b0;
        @(posedge clk);
        @(negedge clk); sync_n = 1'b1;
        @(posedge clk);
      end
      if (i < 3) do_tick(1'b0);
      else if (half_at >= 0 && (i == half_at || i == half_at + 1)) do_tick(1'b0);
      else do_tick(1'b1);
    end
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) do_tick(1'b1);
  endtask

  initial begin
    int sum_h;
    c_prev = 1'b0; c_rise_a = -1; c_rise_b = -1;
    clear_tally();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset los", int'(los), 1);
    chk("R8 reset hsync_n", int'(hsync_n), 1);
    chk("R8 reset porch_n", int'(porch_n), 1);
    rst_n = 1'b1;
    idle_ticks(5);

    // lock build-up; intervals include both window limits 35 and 45
    sum_h = 0;
    run_line(40, -1, -1); sum_h += h_low + p_low;
    run_line(40, -1, -1); sum_h += h_low + p_low;
    run_line(45, -1, -1); sum_h += h_low + p_low;
    run_line(35, -1, -1); sum_h += h_low + p_low;
    for (int k = 0; k < 4; k++) begin run_line(40, -1, -1); sum_h += h_low + p_low; end
    chk("R8 outputs blanked before lock", sum_h, 0);
    chk("R5 no lock after 7 intervals", int'(los), 1);

    run_line(40, -1, -1);
    chk("R5 lock at 8th interval los", int'(los), 0);
    chk("R1 hsync first tick", h_first, 0);
    chk("R1 hsync width", h_low, HSW);
    chk("R2 porch width", p_low, BPW);
    chk("R9 locked clamp width", c_high, BPW);

    // half-line tip inside a locked line
    run_line(40, 20, -1);
    chk("R4 half-line hsync", h_low, HSW);
    chk("R4 half-line porch", p_low, BPW);

    // glitch between ticks has no effect
    run_line(40, -1, 20);
    chk("R10 glitch hsync", h_low, HSW);
    chk("R10 glitch porch", p_low, BPW);

    // rejected edge at 29 ticks, then accepted at exactly 30 (out of window)
    run_line(29, -1, -1);
    chk("R1 short line hsync", h_low, HSW);
    run_line(11, -1, -1);
    chk("R4 rejected edge hsync", h_low, 0);
    chk("R4 rejected edge porch not rearmed", p_low, 3);
    run_line(30, -1, -1);
    chk("R3 accepted at 3/4 limit", h_low, HSW);
    run_line(40, -1, -1);
    chk("R3 accept at exactly 30", h_first, 0);
    chk("R6 lock kept after out-of-window", int'(los), 0);

    // silence: drop exactly at 4*P ticks after last start
    run_line(40, -1, -1);
    idle_ticks(119);
    idle_ticks(1);
    chk("R7 still locked at 159", int'(los), 0);
    idle_ticks(1);
    chk("R7 lock dropped at 160", int'(los), 1);
    chk("R8 hsync blanked after loss", int'(hsync_n), 1);

    // free-running clamp
    idle_ticks(5);
    clear_tally();
    for (int i = 0; i < 2 * P; i++) do_tick(1'b1);
    chk("R9 free-run clamp duty", c_high, 2 * BPW);
    chk("R8 porch blanked unlocked", p_low, 0);
    chk("R9 free-run period", c_rise_b - c_rise_a, P);

    // relock through a long interval that restarts the run
    sum_h = 0;
    run_line(40, -1, -1); sum_h += h_low;
    run_line(46, -1, -1); sum_h += h_low;
    for (int k = 0; k < 8; k++) begin run_line(40, -1, -1); sum_h += h_low; end
    chk("R6 long interval restarts run", sum_h, 0);
    run_line(40, -1, -1);
    chk("R6 relock after full run", h_low, HSW);
    chk("R8 los low when locked", int'(los), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule